// File: doc/BRIEF.md
# Cycle-Table Horizontal Display-Enable Generator

This block produces the horizontal timing of one scanline from a free-running cycle counter. At a small set of fixed cycle positions it looks at two configuration levels, a resolution select (low or high) and a refresh select (50 Hz or 60 Hz). From what it sees it sets or clears a horizontal enable flag, drives blanking and horizontal sync, and picks how long the current line is. Software that rewrites the two selects at the right moment can open borders, shorten lines or lengthen them, so the exact sample cycle of every check matters.

Each check reads the refresh select first and the resolution select one cycle later. A two-bit phase input, fixed at power-up and untouched by reset, delays every check by 0 to 3 cycles to model the four power-on alignments between the timing logic and the processor. A registered display enable combines the horizontal flag with an external vertical enable, and an end-of-line strobe marks the last cycle of every line.

Top module: `hde_gen`

## Requirements
- R1: Cycle 0 is the first cycle after reset is released. The counter runs from 0 up to the line length minus one, `eol_o` is high only in that last cycle, and the next cycle is cycle 0 of a new line. Every line starts at length 508; the check at table position 54 changes it to 224 when the resolution sample is high, or to 512 when the resolution sample is low and the refresh sample reads 50 Hz.
- R2: In low resolution, H is set at position 52 when refresh reads 60 Hz and at position 56 when it reads 50 Hz; it is cleared at position 372 for 60 Hz and at position 376 for 50 Hz.
- R3: In high resolution, H is set at position 4 and cleared at position 164, and BLANK is raised at position 184. These three checks apply whatever BLANK is.
- R4: In low resolution, BLANK is cleared at position 30 and raised at position 450.
- R5: In low resolution, HSYNC is raised at position 462 and cleared at position 502; the position-462 check also clears H, so H and HSYNC change in the same cycle.
- R6: For table position P with phase offset K, the refresh select (`freq50_i`, 1 = 50 Hz) is sampled in cycle P+K and the resolution select (`res_hi_i`, 1 = high) in cycle P+K+1; the resulting change shows on the outputs from cycle P+K+2.
- R7: The phase input `phase_i` (0 to 3) shifts every check of R1 to R5 later by that many cycles.
- R8: `de_o` equals H ANDed with `ven_i` (as seen in the check cycle) and changes in the same cycle as H; with `ven_i` low it stays low while H is high.
- R9: While BLANK is high, the low-resolution H checks at positions 52, 56, 372 and 376 have no effect.
- R10: An active-low synchronous reset clears the counter, H, BLANK, HSYNC and DE, and returns the line length to 508; the phase input keeps its value.
- R11: A select value that is present only in cycles where no check samples it has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cycle clock |
| rst_n | input | 1 | Synchronous reset, active low |
| res_hi_i | input | 1 | Resolution select, 1 = high resolution |
| freq50_i | input | 1 | Refresh select, 1 = 50 Hz, 0 = 60 Hz |
| phase_i | input | 2 | Power-on phase offset, 0 to 3 cycles |
| ven_i | input | 1 | Vertical enable from the frame timing |
| h_o | output | 1 | Horizontal enable flag |
| blank_o | output | 1 | Blanking active |
| hsync_o | output | 1 | Horizontal sync active |
| de_o | output | 1 | Registered display enable |
| eol_o | output | 1 | High in the last cycle of the line |

## Verification
The sharpest collision is the sync check at position 462 clearing a horizontal enable that the line-end checks left standing: the bench raises the resolution select across the 376 sample so H survives, then expects H, DE and HSYNC all to change in the one cycle 464 and not a cycle earlier. A second collision is a missed blank release meeting the low-resolution H set in the next line, judged by H and DE staying low. The split sampling is probed by pulsing each select for a single cycle on either side of the check, with phase 0 and phase 3.

// File: rtl/hde_pkg.sv
// Shared constants and types for the horizontal display-enable generator.
// Assumes one counter cycle per clock; positions are table positions
// before the phase offset and resolution lag are added.
package hde_pkg;

    // line lengths in cycles
    localparam int LEN_PAL  = 512;
    localparam int LEN_NTSC = 508;
    localparam int LEN_HI   = 224;

    localparam int CNT_W   = $clog2(LEN_PAL);
    localparam int PH_W    = 2;
    localparam int RES_LAG = 1;

    typedef logic [CNT_W-1:0] cyc_t;

    // last cycle index of each line kind
    localparam cyc_t LAST_PAL  = cyc_t'(LEN_PAL - 1);
    localparam cyc_t LAST_NTSC = cyc_t'(LEN_NTSC - 1);
    localparam cyc_t LAST_HI   = cyc_t'(LEN_HI - 1);

    // table positions
    localparam cyc_t P_HI_H_ON      = cyc_t'(4);
    localparam cyc_t P_LO_BLANK_OFF = cyc_t'(30);
    localparam cyc_t P_LO_H_ON_60   = cyc_t'(52);
    localparam cyc_t P_LEN_SEL      = cyc_t'(54);
    localparam cyc_t P_LO_H_ON_50   = cyc_t'(56);
    localparam cyc_t P_HI_H_OFF     = cyc_t'(164);
    localparam cyc_t P_HI_BLANK_ON  = cyc_t'(184);
    localparam cyc_t P_LO_H_OFF_60  = cyc_t'(372);
    localparam cyc_t P_LO_H_OFF_50  = cyc_t'(376);
    localparam cyc_t P_LO_BLANK_ON  = cyc_t'(450);
    localparam cyc_t P_LO_SYNC_ON   = cyc_t'(462);
    localparam cyc_t P_LO_SYNC_OFF  = cyc_t'(502);

endpackage

// File: rtl/hde_cycle_ctr.sv
// Line cycle counter. Counts from 0 to the current last index and wraps.
// Assumes last_i is a registered value that only changes mid-line.
module hde_cycle_ctr
    import hde_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cyc_t last_i,
    output cyc_t cyc_o,
    output logic eol_o
);

    cyc_t cyc_q;

    // end of line once the counter reaches the last index (R1)
    assign eol_o = (cyc_q >= last_i);
    assign cyc_o = cyc_q;

    // advance the counter, wrap at end of line, clear on reset (R10)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (eol_o) begin
            cyc_q <= '0;
        end else begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

endmodule

// File: rtl/hde_sampler.sv
// Sample alignment. Delays the refresh select by RES_LAG cycles so that it
// lines up with the later resolution sample, and maps the counter to the
// table position being checked this cycle, removing phase and lag.
// Assumes phase_i is static during operation.
module hde_sampler
    import hde_pkg::*;
#(
    parameter int PH_W_P    = PH_W,
    parameter int RES_LAG_P = RES_LAG
) (
    input  logic            clk,
    input  logic            rst_n,
    input  cyc_t            cyc_i,
    input  logic [PH_W_P-1:0] phase_i,
    input  logic            freq50_i,
    output logic            freq50_s_o,
    output cyc_t            pos_o,
    output logic            pos_vld_o
);

    localparam int DW = CNT_W + 1;

    logic [RES_LAG_P:0] fq;
    logic [DW-1:0]      diff;

    assign fq[0] = freq50_i;

    // one register stage per cycle of resolution lag (R6)
    for (genvar i = 1; i <= RES_LAG_P; i++) begin : g_lag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fq[i] <= 1'b0;
            end else begin
                fq[i] <= fq[i-1];
            end
        end
    end

    assign freq50_s_o = fq[RES_LAG_P];

    // table position = cycle - phase - lag; negative means no check (R7)
    always_comb begin
        diff      = {1'b0, cyc_i} - (DW'(phase_i) + DW'(RES_LAG_P));
        pos_o     = diff[CNT_W-1:0];
        pos_vld_o = ~diff[DW-1];
    end

endmodule

// File: rtl/hde_action.sv
// Action table and line flags. Applies the check at the current table
// position using the delayed refresh sample and the live resolution level,
// and holds H, BLANK, HSYNC, DE and the selected line length.
// Assumes pos_i/pos_vld_i come from hde_sampler in the same cycle.
module hde_action
    import hde_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cyc_t pos_i,
    input  logic pos_vld_i,
    input  logic res_hi_i,
    input  logic freq50_s_i,
    input  logic eol_i,
    input  logic ven_i,
    output logic h_o,
    output logic blank_o,
    output logic hsync_o,
    output logic de_o,
    output cyc_t last_o
);

    logic h_q, bl_q, hs_q, de_q;
    logic h_n, bl_n, hs_n;
    cyc_t last_q, last_n;
    logic lo, gate;

    assign lo   = ~res_hi_i;
    assign gate = ~bl_q;

    // decode the table entry for this cycle into next flag values
    always_comb begin
        h_n    = h_q;
        bl_n   = bl_q;
        hs_n   = hs_q;
        last_n = last_q;
        if (pos_vld_i) begin
            case (pos_i)
                P_HI_H_ON:      if (res_hi_i) h_n = 1'b1;                          // R3
                P_LO_BLANK_OFF: if (lo) bl_n = 1'b0;                               // R4
                P_LO_H_ON_60:   if (lo && !freq50_s_i && gate) h_n = 1'b1;         // R2 R9
                P_LEN_SEL: begin                                                   // R1
                    if (res_hi_i)        last_n = LAST_HI;
                    else if (freq50_s_i) last_n = LAST_PAL;
                end
                P_LO_H_ON_50:   if (lo && freq50_s_i && gate) h_n = 1'b1;          // R2 R9
                P_HI_H_OFF:     if (res_hi_i) h_n = 1'b0;                          // R3
                P_HI_BLANK_ON:  if (res_hi_i) bl_n = 1'b1;                         // R3
                P_LO_H_OFF_60:  if (lo && !freq50_s_i && gate) h_n = 1'b0;         // R2 R9
                P_LO_H_OFF_50:  if (lo && freq50_s_i && gate) h_n = 1'b0;          // R2 R9
                P_LO_BLANK_ON:  if (lo) bl_n = 1'b1;                               // R4
                P_LO_SYNC_ON: begin                                                // R5
                    if (lo) begin
                        hs_n = 1'b1;
                        h_n  = 1'b0;
                    end
                end
                P_LO_SYNC_OFF:  if (lo) hs_n = 1'b0;                               // R5
                default: ;
            endcase
        end
        if (eol_i) begin
            last_n = LAST_NTSC;
        end
    end

    // register flags, line length and display enable (R8, R10)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q    <= 1'b0;
            bl_q   <= 1'b0;
            hs_q   <= 1'b0;
            de_q   <= 1'b0;
            last_q <= LAST_NTSC;
        end else begin
            h_q    <= h_n;
            bl_q   <= bl_n;
            hs_q   <= hs_n;
            de_q   <= h_n & ven_i;
            last_q <= last_n;
        end
    end

    assign h_o     = h_q;
    assign blank_o = bl_q;
    assign hsync_o = hs_q;
    assign de_o    = de_q;
    assign last_o  = last_q;

endmodule

// File: rtl/hde_gen.sv
// Top of the horizontal display-enable generator: counter, sample
// alignment and action table. Assumes phase_i is fixed after power-up.
module hde_gen
    import hde_pkg::*;
#(
    parameter int PH_W_P    = PH_W,
    parameter int RES_LAG_P = RES_LAG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_hi_i,
    input  logic              freq50_i,
    input  logic [PH_W_P-1:0] phase_i,
    input  logic              ven_i,
    output logic              h_o,
    output logic              blank_o,
    output logic              hsync_o,
    output logic              de_o,
    output logic              eol_o
);

    cyc_t cyc, pos, last;
    logic pos_vld, freq50_s;

    hde_cycle_ctr u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .last_i (last),
        .cyc_o  (cyc),
        .eol_o  (eol_o)
    );

    hde_sampler #(
        .PH_W_P    (PH_W_P),
        .RES_LAG_P (RES_LAG_P)
    ) u_smp (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_i      (cyc),
        .phase_i    (phase_i),
        .freq50_i   (freq50_i),
        .freq50_s_o (freq50_s),
        .pos_o      (pos),
        .pos_vld_o  (pos_vld)
    );

    hde_action u_act (
        .clk        (clk),
        .rst_n      (rst_n),
        .pos_i      (pos),
        .pos_vld_i  (pos_vld),
        .res_hi_i   (res_hi_i),
        .freq50_s_i (freq50_s),
        .eol_i      (eol_o),
        .ven_i      (ven_i),
        .h_o        (h_o),
        .blank_o    (blank_o),
        .hsync_o    (hsync_o),
        .de_o       (de_o),
        .last_o     (last)
    );

endmodule

// File: rtl/hde_gen_chk.sv
// Property checker for hde_gen, attached by bind. Tracks line length with
// its own counter rather than a long $past window.
module hde_gen_chk
    import hde_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic h_o,
    input logic blank_o,
    input logic hsync_o,
    input logic de_o,
    input logic eol_o
);

    int unsigned run_cnt;

    // cycles since the start of the line, independent of the design counter
    always_ff @(posedge clk) begin
        if (!rst_n || eol_o) begin
            run_cnt <= 0;
        end else begin
            run_cnt <= run_cnt + 1;
        end
    end

    // R1: every line ends after one of the three legal lengths
    p_line_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        eol_o |-> (run_cnt == LEN_PAL - 1 || run_cnt == LEN_NTSC - 1 || run_cnt == LEN_HI - 1));

    // R1: end-of-line strobe lasts one cycle
    p_eol_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        eol_o |=> !eol_o);

    // R5: sync start never leaves H standing
    p_sync_drops_h_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync_o) |-> !h_o);

    // R8: display enable only with H
    p_de_needs_h_r8: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> h_o);

    // R10: reset leaves all flags low
    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> (!h_o && !blank_o && !hsync_o && !de_o && !eol_o));

endmodule

bind hde_gen hde_gen_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .h_o     (h_o),
    .blank_o (blank_o),
    .hsync_o (hsync_o),
    .de_o    (de_o),
    .eol_o   (eol_o)
);

// File: tb/hde_gen_tb.sv
// Scoreboard bench: scenario tasks push expected output values per cycle,
// a monitor pops and compares them late in each cycle.
module hde_gen_tb;

    localparam int SH = 0, SB = 1, SS = 2, SD = 3, SE = 4;

    typedef struct {
        int    cyc;
        int    sig;
        bit    val;
        string req;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       res_hi_i = 1'b0;
    logic       freq50_i = 1'b0;
    logic [1:0] phase_i = 2'd0;
    logic       ven_i = 1'b1;
    logic       h_o, blank_o, hsync_o, de_o, eol_o;

    item_t q[$];
    item_t mit;
    int    checks = 0;
    int    fails = 0;
    int    tcyc = 0;
    bit    mon_en = 1'b0;

    // scenario stimulus settings
    bit res_base, freq_base;
    int rw_lo, rw_hi, fw_lo, fw_hi;

    always #10 clk = ~clk;

    hde_gen u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .res_hi_i (res_hi_i),
        .freq50_i (freq50_i),
        .phase_i  (phase_i),
        .ven_i    (ven_i),
        .h_o      (h_o),
        .blank_o  (blank_o),
        .hsync_o  (hsync_o),
        .de_o     (de_o),
        .eol_o    (eol_o)
    );

    function automatic bit sigval(int s);
        case (s)
            SH:      return h_o;
            SB:      return blank_o;
            SS:      return hsync_o;
            SD:      return de_o;
            default: return eol_o;
        endcase
    endfunction

    function automatic string signame(int s);
        case (s)
            SH:      return "h";
            SB:      return "blank";
            SS:      return "hsync";
            SD:      return "de";
            default: return "eol";
        endcase
    endfunction

    // monitor: compares queued expectations late in each cycle
    always @(posedge clk) begin
        #15;
        if (mon_en) begin
            while (q.size() > 0 && q[0].cyc <= tcyc) begin
                mit = q.pop_front();
                checks++;
                if (mit.cyc != tcyc || sigval(mit.sig) != mit.val) begin
                    fails++;
                    $display("FAIL %s cycle %0d %s: got %0b expected %0b",
                             mit.req, mit.cyc, signame(mit.sig), sigval(mit.sig), mit.val);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    task automatic expect_at(int c, int s, bit v, string r);
        item_t it;
        it.cyc = c; it.sig = s; it.val = v; it.req = r;
        q.push_back(it);
    endtask

    task automatic cfg(bit res, bit frq, int ph, bit ven);
        res_base = res; freq_base = frq;
        phase_i = 2'(ph); ven_i = ven;
        rw_lo = -1; rw_hi = -1; fw_lo = -1; fw_hi = -1;
        // R10: reset state after whatever the previous scenario left
        expect_at(0, SH, 0, "R10");
        expect_at(0, SB, 0, "R10");
        expect_at(0, SS, 0, "R10");
        expect_at(0, SD, 0, "R10");
        expect_at(0, SE, 0, "R10");
    endtask

    task automatic drive(int c);
        res_hi_i = res_base ^ (c >= rw_lo && c <= rw_hi);
        freq50_i = freq_base ^ (c >= fw_lo && c <= fw_hi);
    endtask

    task automatic run(int n);
        @(negedge clk);
        rst_n = 1'b0;
        drive(0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        tcyc = 0;
        drive(0);
        mon_en = 1'b1;
        for (int c = 1; c <= n; c++) begin
            @(negedge clk);
            tcyc = c;
            drive(c);
        end
        @(posedge clk);
        #16;
        mon_en = 1'b0;
        if (q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL scoreboard: got %0d pending expected 0", q.size());
            q.delete();
        end
    endtask

    initial begin
        // low res 50 Hz, phase 0
        cfg(0, 1, 0, 1);
        expect_at(57, SH, 0, "R2");   expect_at(58, SH, 1, "R2");
        expect_at(58, SD, 1, "R8");
        expect_at(377, SH, 1, "R2");  expect_at(378, SH, 0, "R2");
        expect_at(378, SD, 0, "R8");
        expect_at(451, SB, 0, "R4");  expect_at(452, SB, 1, "R4");
        expect_at(463, SS, 0, "R5");  expect_at(464, SS, 1, "R5");
        expect_at(503, SS, 1, "R5");  expect_at(504, SS, 0, "R5");
        expect_at(510, SE, 0, "R1");  expect_at(511, SE, 1, "R1");
        expect_at(512, SE, 0, "R1");
        expect_at(543, SB, 1, "R4");  expect_at(544, SB, 0, "R4");
        expect_at(569, SH, 0, "R2");  expect_at(570, SH, 1, "R2");
        run(575);

        // low res 60 Hz, phase 2
        cfg(0, 0, 2, 1);
        expect_at(55, SH, 0, "R7");   expect_at(56, SH, 1, "R2");
        expect_at(375, SH, 1, "R2");  expect_at(376, SH, 0, "R7");
        expect_at(453, SB, 0, "R4");  expect_at(454, SB, 1, "R7");
        expect_at(465, SS, 0, "R5");  expect_at(466, SS, 1, "R7");
        expect_at(505, SS, 1, "R5");  expect_at(506, SS, 0, "R5");
        expect_at(506, SE, 0, "R1");  expect_at(507, SE, 1, "R1");
        expect_at(508, SE, 0, "R1");
        expect_at(541, SB, 1, "R4");  expect_at(542, SB, 0, "R4");
        run(545);

        // high res, phase 1
        cfg(1, 1, 1, 1);
        expect_at(6, SH, 0, "R3");    expect_at(7, SH, 1, "R3");
        expect_at(166, SH, 1, "R3");  expect_at(167, SH, 0, "R3");
        expect_at(186, SB, 0, "R3");  expect_at(187, SB, 1, "R3");
        expect_at(222, SE, 0, "R1");  expect_at(223, SE, 1, "R1");
        expect_at(224, SE, 0, "R1");
        expect_at(230, SH, 0, "R3");  expect_at(231, SH, 1, "R3");
        expect_at(240, SB, 1, "R3");  expect_at(250, SS, 0, "R3");
        run(252);

        // resolution high only in its own sample cycle: no H
        cfg(0, 1, 0, 1);
        rw_lo = 57; rw_hi = 57;
        expect_at(58, SH, 0, "R6");   expect_at(100, SH, 0, "R11");
        run(102);

        // resolution high only in the refresh sample cycle: ignored
        cfg(0, 1, 0, 1);
        rw_lo = 56; rw_hi = 56;
        expect_at(58, SH, 1, "R11");
        run(60);

        // refresh 60 Hz only in its own sample cycle: no H
        cfg(0, 1, 0, 1);
        fw_lo = 56; fw_hi = 56;
        expect_at(58, SH, 0, "R6");   expect_at(80, SH, 0, "R6");
        run(82);

        // refresh 60 Hz only in the resolution sample cycle: ignored
        cfg(0, 1, 0, 1);
        fw_lo = 57; fw_hi = 57;
        expect_at(58, SH, 1, "R11");
        run(60);

        // phase 3: resolution sampled at cycle 60
        cfg(0, 1, 3, 1);
        rw_lo = 60; rw_hi = 60;
        expect_at(61, SH, 0, "R7");   expect_at(70, SH, 0, "R7");
        run(72);

        // phase 3: cycle 59 is the refresh sample, resolution ignored there
        cfg(0, 1, 3, 1);
        rw_lo = 59; rw_hi = 59;
        expect_at(60, SH, 0, "R7");   expect_at(61, SH, 1, "R7");
        run(63);

        // missed blank release in line two blocks the low-res H set
        cfg(0, 1, 0, 1);
        rw_lo = 530; rw_hi = 550;
        expect_at(58, SH, 1, "R2");   expect_at(452, SB, 1, "R4");
        expect_at(543, SB, 1, "R9");  expect_at(560, SB, 1, "R9");
        expect_at(575, SH, 0, "R9");  expect_at(575, SD, 0, "R9");
        run(577);

        // right border kept open: sync clears H and DE in its own cycle
        cfg(0, 1, 0, 1);
        rw_lo = 370; rw_hi = 380;
        expect_at(58, SH, 1, "R2");   expect_at(378, SH, 1, "R5");
        expect_at(463, SH, 1, "R5");  expect_at(463, SD, 1, "R8");
        expect_at(463, SS, 0, "R5");
        expect_at(464, SH, 0, "R5");  expect_at(464, SS, 1, "R5");
        expect_at(464, SD, 0, "R8");
        run(466);

        // vertical enable low: H runs, DE stays low
        cfg(0, 1, 0, 0);
        expect_at(58, SH, 1, "R8");   expect_at(58, SD, 0, "R8");
        expect_at(90, SD, 0, "R8");
        run(92);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule